// File: doc/BRIEF.md
# ARX 512-bit Compression Engine

This block performs one compression of a 64-bit-word add-rotate-xor hash. It accepts a 1024-bit message block, a 512-bit chaining value and a 64-bit bit counter as one operand bundle. It returns the updated 512-bit chaining value. Sixteen 64-bit working words are kept in registers. One quarter-round mix is evaluated per clock, so one operation takes 128 mixing cycles plus one folding cycle.

Operands enter through a valid/ready handshake. `in_ready` is high only while the engine is idle, so only one operation is in flight at a time. Presenting `in_valid` while the engine is busy does nothing. The result leaves through a second valid/ready handshake. When `out_ready` is held low, the result and its valid flag are frozen until the consumer takes them. This is the only back-pressure point. The engine does not return to idle until the result has been taken, so a stalled consumer also stops new operands from being accepted. The 16-entry constant table and the ten-row index permutation are internal read-only tables.

Top module: `arx512_core`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` and `busy` are 0.
- R2: At a rising edge where `in_valid` and `in_ready` are both 1, the operands are captured. From the next cycle `busy` is 1 and `in_ready` is 0 until the result has been consumed.
- R3: While `busy` is 1, `in_valid` and operand changes are ignored: the result belongs to the captured operands, and no further operation starts.
- R4: `out_valid` first goes high 129 clock cycles after the accepting edge: 16 rounds of 8 mixes each, one mix per cycle, plus one folding cycle.
- R5: Working words 0..7 start as the chaining words, where chaining word i is `in_chain[64i+63:64i]`. Words 8..15 start as constants 0..7 of the internal table. The counter is XORed into words 12 and 13.
- R6: Each of the 16 rounds runs mixes on the column sets (0,4,8,12), (1,5,9,13), (2,6,10,14), (3,7,11,15) and then on the diagonal sets (0,5,10,15), (1,6,11,12), (2,7,8,13), (3,4,9,14). For mix j of round r, the word pair (p0,p1) is taken from positions 2j and 2j+1 of permutation row r mod 10. Each mix on (a,b,c,d) performs, with all sums mod 2^64:
  - a += (m[p0]^k[p1]) + b, then d = rotr(d^a,32), then c += d, then b = rotr(b^c,25);
  - a += (m[p1]^k[p0]) + b, then d = rotr(d^a,16), then c += d, then b = rotr(b^c,11).
- R7: Message word i is `in_block[64i+63:64i]` with its eight bytes reversed, so the lowest byte becomes the most significant.
- R8: Result word i, at `out_chain[64i+63:64i]`, is chaining word i XOR working word i XOR working word i+8 after the last round.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_chain` keeps its value.
- R10: The cycle after an output handshake, `out_valid` is 0 and `in_ready` is 1, so a new operation can be accepted at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand bundle is valid |
| in_ready | output | 1 | Engine idle and able to take operands |
| in_block | input | 1024 | Message block, word i at bits 64i upward |
| in_chain | input | 512 | Chaining value, word i at bits 64i upward |
| in_count | input | 64 | Bit counter mixed into working words 12 and 13 |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_chain | output | 512 | Updated chaining value |
| busy | output | 1 | An operation is in progress or its result is waiting |

## Verification
The checker assumes that `out_ready` may drop at any time while a result is waiting, and that `in_valid` may stay high or carry changing data while the engine is busy. The latency and hold properties rely on the result handshake being the only way back to idle. The stimulus keeps `out_ready` low for several cycles in some operations and high in others. In some operations it keeps `in_valid` high with inverted operands for the whole run, and it always releases `in_valid` before the handshake edge, so any later acceptance can only come from an ignored request. Expected results come from an independent loop-based model of the compression, applied to random operands and to all-zero, counter-only, byte-ramp and all-ones patterns.

// File: rtl/arx512_pkg.sv
package arx512_pkg;

  localparam int WORD_W   = 64;
  localparam int N_STATE  = 16;
  localparam int N_CHAIN  = 8;
  localparam int N_PROWS  = 10;
  localparam int MIX_PER_ROUND = 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FOLD, ST_HOLD} eng_state_t;

  // Sixteen fixed mixing constants.
  function automatic word_t kconst(input logic [3:0] idx);
    case (idx)
      4'd0:  kconst = 64'h243f6a8885a308d3;
      4'd1:  kconst = 64'h13198a2e03707344;
      4'd2:  kconst = 64'ha4093822299f31d0;
      4'd3:  kconst = 64'h082efa98ec4e6c89;
      4'd4:  kconst = 64'h452821e638d01377;
      4'd5:  kconst = 64'hbe5466cf34e90c6c;
      4'd6:  kconst = 64'hc0ac29b7c97c50dd;
      4'd7:  kconst = 64'h3f84d5b5b5470917;
      4'd8:  kconst = 64'h9216d5d98979fb1b;
      4'd9:  kconst = 64'hd1310ba698dfb5ac;
      4'd10: kconst = 64'h2ffd72dbd01adfb7;
      4'd11: kconst = 64'hb8e1afed6a267e96;
      4'd12: kconst = 64'hba7c9045f12c7f99;
      4'd13: kconst = 64'h24a19947b3916cf7;
      4'd14: kconst = 64'h0801f2e2858efc16;
      default: kconst = 64'h636920d871574e69;
    endcase
  endfunction

  // One permutation row packed into 16 nibbles, position 0 in the top nibble.
  function automatic logic [63:0] perm_row(input logic [3:0] row);
    case (row)
      4'd1: perm_row = 64'hEA489FD61C02B753;
      4'd2: perm_row = 64'hB8C052FDAE367194;
      4'd3: perm_row = 64'h7931DCBE265A40F8;
      4'd4: perm_row = 64'h905724AFE1BC683D;
      4'd5: perm_row = 64'h2C6A0B834D75FE19;
      4'd6: perm_row = 64'hC51FED4A0763928B;
      4'd7: perm_row = 64'hDB7EC13950F4862A;
      4'd8: perm_row = 64'h6FE9B308C2D714A5;
      4'd9: perm_row = 64'hA2847615FB9E3CD0;
      default: perm_row = 64'h0123456789ABCDEF;
    endcase
  endfunction

  function automatic logic [3:0] perm_pick(input logic [63:0] rowv, input logic [3:0] pos);
    logic [5:0] sh;
    sh = 6'd60 - {pos, 2'b00};
    perm_pick = 4'(rowv >> sh);
  endfunction

  function automatic word_t byte_rev(input word_t w);
    for (int i = 0; i < WORD_W / 8; i++) begin
      byte_rev[8*i +: 8] = w[WORD_W-8-8*i +: 8];
    end
  endfunction

  function automatic word_t rotr(input word_t x, input int n);
    rotr = (x >> n) | (x << (WORD_W - n));
  endfunction

endpackage

// File: rtl/arx512_seq.sv
module arx512_seq
  import arx512_pkg::*;
#(
  parameter int N_ROUNDS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       last,
  output logic [3:0] ia,
  output logic [3:0] ib,
  output logic [3:0] ic,
  output logic [3:0] id,
  output logic [3:0] p0,
  output logic [3:0] p1
);

  localparam int N_STEPS = N_ROUNDS * MIX_PER_ROUND;
  localparam int STEP_W  = $clog2(N_STEPS);

  logic [STEP_W-1:0] step_q;
  logic              run_q;
  logic [STEP_W-4:0] round;
  logic [2:0]        mix;
  logic [1:0]        lane;
  logic [3:0]        row;
  logic [63:0]       rowv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0;
      run_q  <= 1'b0;
    end else if (start) begin
      step_q <= '0;
      run_q  <= 1'b1;
    end else if (run_q) begin
      if (last) run_q <= 1'b0;
      step_q <= step_q + 1'b1;
    end
  end

  assign last  = run_q && (step_q == STEP_W'(N_STEPS - 1));
  assign round = step_q[STEP_W-1:3];
  assign mix   = step_q[2:0];
  assign lane  = mix[1:0];

  // Column mixes keep the lane; diagonal mixes rotate rows b, c, d by 1, 2, 3.
  always_comb begin
    ia = {2'b00, lane};
    if (!mix[2]) begin
      ib = {2'b01, lane};
      ic = {2'b10, lane};
      id = {2'b11, lane};
    end else begin
      ib = {2'b01, lane + 2'd1};
      ic = {2'b10, lane + 2'd2};
      id = {2'b11, lane + 2'd3};
    end
  end

  assign row  = 4'(int'(round) % N_PROWS);
  assign rowv = perm_row(row);
  assign p0   = perm_pick(rowv, {mix, 1'b0});
  assign p1   = perm_pick(rowv, {mix, 1'b1});

endmodule

// File: rtl/arx512_opsel.sv
module arx512_opsel
  import arx512_pkg::*;
(
  input  logic [N_STATE-1:0][WORD_W-1:0] vstate,
  input  logic [N_STATE-1:0][WORD_W-1:0] msg,
  input  logic [3:0]                     ia,
  input  logic [3:0]                     ib,
  input  logic [3:0]                     ic,
  input  logic [3:0]                     id,
  input  logic [3:0]                     p0,
  input  logic [3:0]                     p1,
  output word_t                          a,
  output word_t                          b,
  output word_t                          c,
  output word_t                          d,
  output word_t                          x0,
  output word_t                          x1
);

  assign a  = vstate[ia];
  assign b  = vstate[ib];
  assign c  = vstate[ic];
  assign d  = vstate[id];
  assign x0 = msg[p0] ^ kconst(p1);
  assign x1 = msg[p1] ^ kconst(p0);

endmodule

// File: rtl/arx512_mix.sv
module arx512_mix
  import arx512_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  input  word_t x0,
  input  word_t x1,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);

  word_t a1, b1, c1, d1;

  always_comb begin
    a1  = a_i + x0 + b_i;
    d1  = rotr(d_i ^ a1, 32);
    c1  = c_i + d1;
    b1  = rotr(b_i ^ c1, 25);
    a_o = a1 + x1 + b1;
    d_o = rotr(d1 ^ a_o, 16);
    c_o = c1 + d_o;
    b_o = rotr(b1 ^ c_o, 11);
  end

endmodule

// File: rtl/arx512_core.sv
module arx512_core
  import arx512_pkg::*;
#(
  parameter int N_ROUNDS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1023:0] in_block,
  input  logic [511:0]  in_chain,
  input  logic [63:0]   in_count,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [511:0]  out_chain,
  output logic          busy
);

  eng_state_t fsm_q;
  logic [N_STATE-1:0][WORD_W-1:0] v_q, v_init;
  logic [N_STATE-1:0][WORD_W-1:0] m_q, m_init;
  logic [N_CHAIN-1:0][WORD_W-1:0] h_q, fold;
  logic [511:0] res_q;

  logic       accept, last;
  logic [3:0] ia, ib, ic, id, p0, p1;
  word_t      a, b, c, d, x0, x1, na, nb, nc, nd;

  assign accept = in_valid && in_ready;

  // Load path: message byte reversal and working-state initialisation.
  for (genvar i = 0; i < N_STATE; i++) begin : g_msg
    assign m_init[i] = byte_rev(in_block[WORD_W*i +: WORD_W]);
  end

  for (genvar i = 0; i < N_CHAIN; i++) begin : g_init
    assign v_init[i] = in_chain[WORD_W*i +: WORD_W];
    if (i == 4 || i == 5) begin : g_cnt
      assign v_init[N_CHAIN+i] = kconst(4'(i)) ^ in_count;
    end else begin : g_plain
      assign v_init[N_CHAIN+i] = kconst(4'(i));
    end
    assign fold[i] = h_q[i] ^ v_q[i] ^ v_q[N_CHAIN+i];
  end

  arx512_seq #(.N_ROUNDS(N_ROUNDS)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .last  (last),
    .ia    (ia),
    .ib    (ib),
    .ic    (ic),
    .id    (id),
    .p0    (p0),
    .p1    (p1)
  );

  arx512_opsel u_sel (
    .vstate (v_q),
    .msg    (m_q),
    .ia     (ia),
    .ib     (ib),
    .ic     (ic),
    .id     (id),
    .p0     (p0),
    .p1     (p1),
    .a      (a),
    .b      (b),
    .c      (c),
    .d      (d),
    .x0     (x0),
    .x1     (x1)
  );

  arx512_mix u_mix (
    .a_i (a),
    .b_i (b),
    .c_i (c),
    .d_i (d),
    .x0  (x0),
    .x1  (x1),
    .a_o (na),
    .b_o (nb),
    .c_o (nc),
    .d_o (nd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q <= ST_IDLE;
      v_q   <= '0;
      m_q   <= '0;
      h_q   <= '0;
      res_q <= '0;
    end else begin
      case (fsm_q)
        ST_IDLE: begin
          if (accept) begin
            v_q   <= v_init;
            m_q   <= m_init;
            h_q   <= in_chain;
            fsm_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          for (int k = 0; k < N_STATE; k++) begin
            if (4'(k) == ia) v_q[k] <= na;
            if (4'(k) == ib) v_q[k] <= nb;
            if (4'(k) == ic) v_q[k] <= nc;
            if (4'(k) == id) v_q[k] <= nd;
          end
          if (last) fsm_q <= ST_FOLD;
        end
        ST_FOLD: begin
          res_q <= fold;
          fsm_q <= ST_HOLD;
        end
        default: begin
          if (out_ready) fsm_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign in_ready  = (fsm_q == ST_IDLE);
  assign busy      = (fsm_q != ST_IDLE);
  assign out_valid = (fsm_q == ST_HOLD);
  assign out_chain = res_q;

endmodule

// File: rtl/arx512_core_chk.sv
module arx512_core_chk #(
  parameter int N_ROUNDS = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [511:0] out_chain,
  input logic         busy
);

  localparam int LAT = N_ROUNDS * 8 + 1;

  logic [15:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) lat_cnt <= 16'hFFFF;
    else if (in_valid && in_ready) lat_cnt <= '0;
    else if (lat_cnt != 16'hFFFF) lat_cnt <= lat_cnt + 1'b1;
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> busy && !in_ready);

  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && in_valid && !out_valid |=> busy && !in_ready);

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat_cnt == 16'(LAT));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_chain));

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready && !out_valid);

endmodule

bind arx512_core arx512_core_chk #(.N_ROUNDS(N_ROUNDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_chain (out_chain),
  .busy      (busy)
);

// File: tb/arx512_core_bench.sv
module arx512_core_bench;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_ready, out_valid, out_ready, busy;
  logic [1023:0] in_block;
  logic [511:0]  in_chain, out_chain;
  logic [63:0]   in_count;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  arx512_core u_arx512_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_block  (in_block),
    .in_chain  (in_chain),
    .in_count  (in_count),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_chain (out_chain),
    .busy      (busy)
  );

  logic [63:0] tk [16] = '{
    64'h243f6a8885a308d3, 64'h13198a2e03707344, 64'ha4093822299f31d0, 64'h082efa98ec4e6c89,
    64'h452821e638d01377, 64'hbe5466cf34e90c6c, 64'hc0ac29b7c97c50dd, 64'h3f84d5b5b5470917,
    64'h9216d5d98979fb1b, 64'hd1310ba698dfb5ac, 64'h2ffd72dbd01adfb7, 64'hb8e1afed6a267e96,
    64'hba7c9045f12c7f99, 64'h24a19947b3916cf7, 64'h0801f2e2858efc16, 64'h636920d871574e69};
  logic [63:0] tsig [10] = '{
    64'h0123456789ABCDEF, 64'hEA489FD61C02B753, 64'hB8C052FDAE367194, 64'h7931DCBE265A40F8,
    64'h905724AFE1BC683D, 64'h2C6A0B834D75FE19, 64'hC51FED4A0763928B, 64'hDB7EC13950F4862A,
    64'h6FE9B308C2D714A5, 64'hA2847615FB9E3CD0};
  int qa [8] = '{0, 1, 2, 3, 0, 1, 2, 3};
  int qb [8] = '{4, 5, 6, 7, 5, 6, 7, 4};
  int qc [8] = '{8, 9, 10, 11, 10, 11, 8, 9};
  int qd [8] = '{12, 13, 14, 15, 15, 12, 13, 14};

  function automatic logic [63:0] ror(logic [63:0] x, int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  function automatic logic [511:0] golden(logic [1023:0] blk, logic [511:0] ch, logic [63:0] cnt);
    logic [63:0] v [16];
    logic [63:0] m [16];
    logic [511:0] r;
    for (int i = 0; i < 16; i++) begin
      logic [63:0] w;
      w = blk[64*i +: 64];
      m[i] = {<<8{w}};
    end
    for (int i = 0; i < 8; i++) begin
      v[i]   = ch[64*i +: 64];
      v[i+8] = tk[i];
    end
    v[12] ^= cnt;
    v[13] ^= cnt;
    for (int rd = 0; rd < 16; rd++) begin
      for (int j = 0; j < 8; j++) begin
        int s0, s1, a, b, c, d;
        s0 = int'(tsig[rd % 10][63-8*j -: 4]);
        s1 = int'(tsig[rd % 10][59-8*j -: 4]);
        a = qa[j]; b = qb[j]; c = qc[j]; d = qd[j];
        v[a] = v[a] + (m[s0] ^ tk[s1]) + v[b];
        v[d] = ror(v[d] ^ v[a], 32);
        v[c] = v[c] + v[d];
        v[b] = ror(v[b] ^ v[c], 25);
        v[a] = v[a] + (m[s1] ^ tk[s0]) + v[b];
        v[d] = ror(v[d] ^ v[a], 16);
        v[c] = v[c] + v[d];
        v[b] = ror(v[b] ^ v[c], 11);
      end
    end
    for (int i = 0; i < 8; i++) r[64*i +: 64] = ch[64*i +: 64] ^ v[i] ^ v[i+8];
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [511:0] act, logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(logic [1023:0] blk, logic [511:0] ch, logic [63:0] cnt,
                        string tag, int hold, bit poke);
    logic [511:0] exp;
    int n;
    exp = golden(blk, ch, cnt);
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 idle before start", 512'(in_ready), 512'd1);
    in_valid = 1'b1; in_block = blk; in_chain = ch; in_count = cnt;
    out_ready = (hold == 0);
    @(posedge clk);
    @(negedge clk);
    chk(busy && !in_ready, "R2 busy after accept", {busy, in_ready}, 512'b10);
    if (poke) begin
      in_block = ~blk; in_chain = ~ch; in_count = ~cnt;
    end else begin
      in_valid = 1'b0;
    end
    n = 0;
    while (!out_valid && n < 400) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    chk(n == 129, "R4 latency", 512'(n), 512'd129);
    chk(out_chain == exp, tag, out_chain, exp);
    if (poke) chk(out_chain == exp, "R3 result from captured operands", out_chain, exp);
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk(out_valid && out_chain == exp, "R9 held result", out_chain, exp);
      out_ready = 1'b1;
    end
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(!out_valid && in_ready, "R10 release", {out_valid, in_ready}, 512'b01);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(!busy, "R3 no operation started from ignored request", 512'(busy), 512'd0);
    end
  endtask

  function automatic logic [1023:0] rnd_blk();
    logic [1023:0] r;
    for (int i = 0; i < 32; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [511:0] rnd_ch();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [1023:0] ramp;
    void'($urandom(32'd20241));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_block = '0; in_chain = '0; in_count = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid && !busy, "R1 reset state",
        {in_ready, out_valid, busy}, 512'b100);

    run_op('0, '0, 64'd0, "R6 all-zero operands", 0, 1'b0);
    run_op('0, '0, 64'd512, "R5 counter injection", 0, 1'b0);
    run_op('0, '0, 64'hFFFF_FFFF_FFFF_FFFF, "R5 full counter", 2, 1'b0);
    for (int i = 0; i < 128; i++) ramp[8*i +: 8] = 8'(i);
    run_op(ramp, '0, 64'd1024, "R7 byte ramp message", 0, 1'b0);
    run_op('0, '1, 64'd0, "R8 all-ones chaining", 0, 1'b0);
    run_op(rnd_blk(), rnd_ch(), 64'd640, "R3 R6 request while busy", 4, 1'b1);
    for (int t = 0; t < 6; t++) begin
      logic [63:0] cnt;
      cnt = {$urandom, $urandom};
      run_op(rnd_blk(), rnd_ch(), cnt, "R6 R8 random operands", t % 3, t[0]);
    end
    finish_run();
  end

endmodule